// File: doc/BRIEF.md
# Prescaled Event Counter with Watchdog

The block holds an 8-bit event counter and a watchdog that share one 8-bit prescaler. A control byte picks the counter's source (the core's instruction-cycle enable, or one edge of an external pin seen through a synchronizer), the active edge, the divide code, the prescaler's owner, and whether a counter wrap raises an interrupt. The same byte drives a select output that tells the register file whether address 01h holds the working register or the counter.

When the counter owns the prescaler, it advances once every 2^(n+1) source events, where n is the 3-bit divide code. When the watchdog owns the prescaler, the counter advances on every source event and the watchdog advances once every 2^n base ticks. A wrap from FFh to 00h sets a sticky flag. The watchdog is a two-state machine. In WD_RUN it counts its ticks. The transition *expire* (WDT_PERIOD ticks without a clear) moves it to WD_FIRE, where the reset request is high for one cycle. The transition *settle* then returns it to WD_RUN.

Top module: `rtcc_wdt_unit`

## Requirements
- R1: After reset the control byte reads FFh, the counter reads 00h, irq and wdt_rst_req are 0 and map_sel is 1.
- R2: Control bit 7 drives map_sel (1 = address 01h selects the counter, 0 = the working register). A control write takes effect on the next cycle.
- R3: Control bit 5 selects the count source: 0 = each cycle with inst_en high, 1 = a transition of ext_pin. The pin passes two synchronizing flops, so a pin change reaches the counter at the third rising clock edge.
- R4: Control bit 4 selects the pin edge: 0 = low-to-high, 1 = high-to-low.
- R5: With control bit 3 at 1 the counter steps once per source event. With bit 3 at 0 it steps once per 2^(n+1) source events, where n = control bits 2:0.
- R6: With control bit 3 at 1 the watchdog steps once per 2^n pulses of wdt_tick. With bit 3 at 0 it steps on every pulse.
- R7: A counter write loads cnt_wdata on the next edge, takes priority over a coincident count, and clears the prescaler.
- R8: A count step from FFh to 00h sets a sticky flag, and irq = flag AND NOT control bit 6.
- R9: roll_clr clears the flag, but a wrap in the same cycle leaves it set.
- R10: After WDT_PERIOD watchdog steps with no clear, wdt_rst_req is high for exactly one cycle and the count restarts from zero.
- R11: wdt_clr zeroes the watchdog count and the prescaler. A watchdog step in the same cycle is discarded, so no request follows.
- R12: A control write that changes bit 3 clears the prescaler.
- R13: cnt_rdata and opt_rdata always show the current counter and control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opt_we | input | 1 | Control byte write strobe |
| opt_wdata | input | 8 | Control byte write data |
| opt_rdata | output | 8 | Control byte read-back |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write data |
| cnt_rdata | output | 8 | Counter read-back |
| inst_en | input | 1 | Instruction-cycle enable |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_tick | input | 1 | Base watchdog tick |
| wdt_clr | input | 1 | Watchdog clear |
| roll_clr | input | 1 | Wrap flag clear |
| irq | output | 1 | Counter wrap interrupt |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |
| map_sel | output | 1 | Address 01h select (1 = counter) |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a counter wrap and a flag clear. The bench loads FFh with the instruction enable held high and raises roll_clr in the wrapping cycle, then checks that irq stays high; a later clear on its own must drop it. The second pair is a final watchdog step and a watchdog clear. With a divide of one and a tick every cycle, the bench raises the clear on exactly the step that would expire the count and checks that no request appears. In every other cycle, including a long pseudo-random run, a behavioural model in the bench judges all outputs.

// File: rtl/rtcc_wdt_pkg.sv
package rtcc_wdt_pkg;
    typedef enum logic {
        WD_RUN  = 1'b0,
        WD_FIRE = 1'b1
    } wd_state_t;

    typedef struct packed {
        logic       map_cnt;
        logic       irq_off;
        logic       src_pin;
        logic       fall_edge;
        logic       pre_to_wdt;
        logic [2:0] div_code;
    } ctrl_t;
endpackage

// File: rtl/rtcc_pin_sync.sv
module rtcc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;
    assign fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/rtcc_prescaler.sv
module rtcc_prescaler #(
    parameter int SEL_W = 3,
    localparam int PW   = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_pulse,
    input  logic             clear,
    input  logic             to_wdt,
    input  logic [SEL_W-1:0] code,
    output logic             out_pulse
);
    logic [PW-1:0] count;
    logic [SEL_W:0] shamt;
    logic [PW:0]    span;

    always_comb begin
        shamt = to_wdt ? {1'b0, code} : ({1'b0, code} + 1'b1);
        span  = ((PW+1)'(1) << shamt) - (PW+1)'(1);
    end

    assign out_pulse = in_pulse && ((count & span[PW-1:0]) == span[PW-1:0]);

    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (clear)    count <= '0;
        else if (in_pulse) count <= count + 1'b1;
    end
endmodule

// File: rtl/rtcc_wdt_fsm.sv
module rtcc_wdt_fsm
    import rtcc_wdt_pkg::*;
#(
    parameter int WDT_PERIOD = 16,
    localparam int CW = $clog2(WDT_PERIOD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clear,
    output logic fire
);
    wd_state_t     state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          expire;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WD_RUN;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        expire = 1'b0;
        cnt_n  = cnt;
        if (clear) begin
            cnt_n = '0;
        end else if (step) begin
            if (cnt == CW'(WDT_PERIOD - 1)) begin
                cnt_n  = '0;
                expire = 1'b1;
            end else begin
                cnt_n = cnt + 1'b1;
            end
        end
        state_n = state;
        unique case (state)
            WD_RUN:  state_n = expire ? WD_FIRE : WD_RUN;
            WD_FIRE: state_n = expire ? WD_FIRE : WD_RUN;
            default: state_n = WD_RUN;
        endcase
    end

    always_comb begin
        fire = (state == WD_FIRE);
    end
endmodule

// File: rtl/rtcc_wdt_unit.sv
module rtcc_wdt_unit
    import rtcc_wdt_pkg::*;
#(
    parameter int SEL_W       = 3,
    parameter int WDT_PERIOD  = 16,
    parameter int SYNC_STAGES = 2,
    localparam int DW         = 1 << SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          opt_we,
    input  logic [DW-1:0] opt_wdata,
    output logic [DW-1:0] opt_rdata,
    input  logic          cnt_we,
    input  logic [DW-1:0] cnt_wdata,
    output logic [DW-1:0] cnt_rdata,
    input  logic          inst_en,
    input  logic          ext_pin,
    input  logic          wdt_tick,
    input  logic          wdt_clr,
    input  logic          roll_clr,
    output logic          irq,
    output logic          wdt_rst_req,
    output logic          map_sel
);
    ctrl_t         ctrl;
    logic [DW-1:0] cnt_q;
    logic          wrap_flag;
    logic          pin_rise, pin_fall, src_evt;
    logic          pre_in, pre_out, pre_clear;
    logic          cnt_step, wd_step, wrap;

    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl <= ctrl_t'('1);
        else if (opt_we) ctrl <= ctrl_t'(opt_wdata);
    end

    rtcc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin),
        .rise(pin_rise), .fall(pin_fall)
    );

    always_comb begin
        src_evt   = ctrl.src_pin ? (ctrl.fall_edge ? pin_fall : pin_rise) : inst_en;
        pre_in    = ctrl.pre_to_wdt ? wdt_tick : src_evt;
        cnt_step  = ctrl.pre_to_wdt ? src_evt : pre_out;
        wd_step   = ctrl.pre_to_wdt ? pre_out : wdt_tick;
        pre_clear = cnt_we | wdt_clr |
                    (opt_we && (opt_wdata[3] != ctrl.pre_to_wdt));
        wrap      = cnt_step && !cnt_we && (cnt_q == '1);
    end

    rtcc_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .in_pulse(pre_in), .clear(pre_clear),
        .to_wdt(ctrl.pre_to_wdt), .code(ctrl.div_code), .out_pulse(pre_out)
    );

    rtcc_wdt_fsm #(.WDT_PERIOD(WDT_PERIOD)) u_wdt (
        .clk(clk), .rst_n(rst_n), .step(wd_step), .clear(wdt_clr),
        .fire(wdt_rst_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (cnt_we)   cnt_q <= cnt_wdata;
        else if (cnt_step) cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        wrap_flag <= 1'b0;
        else if (wrap)     wrap_flag <= 1'b1;
        else if (roll_clr) wrap_flag <= 1'b0;
    end

    assign opt_rdata = DW'(ctrl);
    assign cnt_rdata = cnt_q;
    assign irq       = wrap_flag & ~ctrl.irq_off;
    assign map_sel   = ctrl.map_cnt;
endmodule

// File: rtl/rtcc_wdt_unit_chk.sv
module rtcc_wdt_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       opt_we,
    input logic       cnt_we,
    input logic [7:0] cnt_wdata,
    input logic [7:0] cnt_rdata,
    input logic       irq_mask,
    input logic       irq,
    input logic       roll_clr,
    input logic       wdt_clr,
    input logic       wdt_rst_req
);
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |=> !wdt_rst_req);

    a_r11_clear_blocks_fire: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_rst_req);

    a_r7_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt_rdata == $past(cnt_wdata)));

    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we |=> (cnt_rdata == $past(cnt_rdata) ||
                     cnt_rdata == $past(cnt_rdata) + 8'd1));

    a_r8_rise_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && !$past(opt_we)) |->
            ($past(cnt_rdata) == 8'hFF && cnt_rdata == 8'h00));

    a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !roll_clr && !opt_we) |=> irq);

    a_r8_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq);
endmodule

bind rtcc_wdt_unit rtcc_wdt_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .opt_we(opt_we), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata), .irq_mask(opt_rdata[6]),
    .irq(irq), .roll_clr(roll_clr), .wdt_clr(wdt_clr),
    .wdt_rst_req(wdt_rst_req)
);

// File: tb/rtcc_wdt_unit_test.sv
module rtcc_wdt_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int TERM       = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       opt_we = 0, cnt_we = 0, inst_en = 0, ext_pin = 0;
    logic       wdt_tick = 0, wdt_clr = 0, roll_clr = 0;
    logic [7:0] opt_wdata = 0, cnt_wdata = 0;
    logic [7:0] opt_rdata, cnt_rdata;
    logic       irq, wdt_rst_req, map_sel;

    int checks = 0, fails = 0;
    string phase = "R1";
    bit running = 0;

    rtcc_wdt_unit #(.WDT_PERIOD(TERM)) uut (
        .clk(clk), .rst_n(rst_n), .opt_we(opt_we), .opt_wdata(opt_wdata),
        .opt_rdata(opt_rdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cnt_rdata(cnt_rdata), .inst_en(inst_en), .ext_pin(ext_pin),
        .wdt_tick(wdt_tick), .wdt_clr(wdt_clr), .roll_clr(roll_clr),
        .irq(irq), .wdt_rst_req(wdt_rst_req), .map_sel(map_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    int m_opt, m_cnt, m_pre, m_wd;
    bit m_flag, m_fire, m_s1, m_s2, m_s3;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_opt = 255; m_cnt = 0; m_pre = 0; m_wd = 0;
            m_flag = 0; m_fire = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            bit evt, src, psa, pin_p, pout, ctk, wtk, fire_n;
            int k, mask;
            evt = m_opt[4] ? (!m_s2 && m_s3) : (m_s2 && !m_s3);
            src = m_opt[5] ? evt : inst_en;
            psa = m_opt[3];
            pin_p = psa ? wdt_tick : src;
            k = psa ? (m_opt & 7) : (m_opt & 7) + 1;
            mask = (1 << k) - 1;
            pout = pin_p && ((m_pre & mask) == mask);
            ctk = psa ? src : pout;
            wtk = psa ? pout : wdt_tick;
            if (ctk && !cnt_we && m_cnt == 255) m_flag = 1;
            else if (roll_clr) m_flag = 0;
            if (cnt_we) m_cnt = cnt_wdata;
            else if (ctk) m_cnt = (m_cnt + 1) % 256;
            if (cnt_we || wdt_clr || (opt_we && opt_wdata[3] != psa)) m_pre = 0;
            else if (pin_p) m_pre = (m_pre + 1) % 256;
            fire_n = 0;
            if (wdt_clr) m_wd = 0;
            else if (wtk) begin
                if (m_wd == TERM - 1) begin m_wd = 0; fire_n = 1; end
                else m_wd++;
            end
            m_fire = fire_n;
            if (opt_we) m_opt = opt_wdata;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            chk({phase, " R13 cnt"}, cnt_rdata, m_cnt);
            chk("R13 opt", opt_rdata, m_opt);
            chk("R2 map_sel", map_sel, (m_opt >> 7) & 1);
            chk({phase, " R8 irq"}, irq, m_flag && !((m_opt >> 6) & 1));
            chk({phase, " R10 rst_req"}, wdt_rst_req, m_fire);
        end
    end

    task automatic nxt();
        @(negedge clk); #1;
    endtask

    task automatic wr_opt(logic [7:0] v);
        opt_we = 1; opt_wdata = v; nxt(); opt_we = 0;
    endtask

    task automatic wr_cnt(logic [7:0] v);
        cnt_we = 1; cnt_wdata = v; nxt(); cnt_we = 0;
    endtask

    logic [15:0] lfsr = 16'hACE1;
    task automatic lstep();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    int fires;
    initial begin
        repeat (3) nxt();
        rst_n = 1; nxt();
        // R1 reset state
        chk("R1 opt", opt_rdata, 8'hFF);
        chk("R1 cnt", cnt_rdata, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rst_req", wdt_rst_req, 0);
        chk("R1 map_sel", map_sel, 1);
        running = 1;

        // R4 falling edge, 1:1 counter; R6 watchdog divided by 128
        phase = "R4";
        wdt_tick = 1;
        for (int i = 0; i < 60; i++) begin
            if (i % 3 == 0) ext_pin = ~ext_pin;
            nxt();
        end
        chk("R4 falling edges counted", cnt_rdata, 10);
        phase = "R6";
        fires = 0;
        for (int i = 0; i < 2200; i++) begin
            if (wdt_rst_req) fires++;
            nxt();
        end
        chk("R10 watchdog fired once", fires, 1);

        // R3 rising edge on pin, irq masked
        phase = "R3";
        wr_opt(8'h68);
        wr_cnt(8'h00);
        for (int i = 0; i < 40; i++) begin
            if (i % 4 == 0) ext_pin = ~ext_pin;
            nxt();
        end
        repeat (4) nxt();
        chk("R3 rising edges counted", cnt_rdata, 5);

        // R2/R12 internal source, prescaler to counter
        phase = "R12";
        inst_en = 1;
        wr_opt(8'h01);
        chk("R2 map_sel cleared", map_sel, 0);
        nxt(); nxt();
        inst_en = 0;
        wr_opt(8'h09);
        wr_opt(8'h01);
        begin
            int base;
            base = cnt_rdata;
            inst_en = 1;
            nxt(); nxt(); nxt();
            chk("R12 no step after 3", cnt_rdata, base);
            nxt();
            chk("R12 step after 4", cnt_rdata, (base + 1) % 256);
        end

        // R7 write beats coincident count
        phase = "R7";
        wr_opt(8'h08);
        cnt_we = 1; cnt_wdata = 8'h40; nxt(); cnt_we = 0; inst_en = 0;
        chk("R7 load priority", cnt_rdata, 8'h40);

        // R9 wrap and clear in the same cycle
        phase = "R9";
        wr_cnt(8'hFF);
        inst_en = 1; roll_clr = 1; nxt();
        inst_en = 0;
        chk("R8 wrap to zero", cnt_rdata, 0);
        chk("R9 set wins over clear", irq, 1);
        nxt(); roll_clr = 0;
        chk("R9 clear alone", irq, 0);

        // R11 clear coincides with expiring step
        phase = "R11";
        wdt_tick = 1;
        wdt_clr = 1; nxt(); wdt_clr = 0;
        fires = 0;
        for (int i = 0; i < TERM - 1; i++) begin
            if (wdt_rst_req) fires++;
            nxt();
        end
        wdt_clr = 1; nxt(); wdt_clr = 0;
        for (int i = 0; i < 3; i++) begin
            if (wdt_rst_req) fires++;
            nxt();
        end
        chk("R11 no fire after coincident clear", fires, 0);
        for (int i = 0; i < TERM; i++) begin
            if (wdt_rst_req) fires++;
            nxt();
        end
        chk("R10 fires after full period", fires, 1);

        // R5 every divide code with counter ownership
        phase = "R5";
        for (int n = 0; n < 8; n++) begin
            wr_opt(8'(n));
            inst_en = 1;
            repeat (300) nxt();
        end
        inst_en = 0;

        // mixed pseudo-random traffic
        phase = "R6";
        for (int i = 0; i < 6000; i++) begin
            lstep();
            inst_en  = lfsr[0];
            wdt_tick = lfsr[1];
            ext_pin  = lfsr[2] & lfsr[3];
            wdt_clr  = (lfsr[15:10] == 0);
            roll_clr = (lfsr[9:5] == 0);
            cnt_we   = (lfsr[15:8] == 8'h5A);
            cnt_wdata = {lfsr[7:4], 4'hE};
            opt_we   = (lfsr[14:6] == 9'h101);
            opt_wdata = lfsr[7:0] & 8'hF3;
            nxt();
        end
        {inst_en, wdt_tick, ext_pin, wdt_clr, roll_clr, cnt_we, opt_we} = '0;
        nxt();
        running = 0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule